// File: doc/BRIEF.md
# HDLC Transmit Pool Controller

This block sits between a host that writes outgoing frame bytes and a bit-level HDLC transmitter. It holds a pool of 32 bytes. The host fills the pool and then commits it with one of two commands. The send-block command hands over a block that is part of a longer frame. The message-end command hands over the final block of a frame. While a committed block drains, the pool is closed to the host. When the last byte of the block has been taken, a one-cycle pool-ready event invites the host to write the next block.

The transmitter takes bytes over a valid/ready handshake, and a last-byte marker goes with the final byte of a frame. Two host mistakes are reported. Writing past 32 bytes before a command raises the overflow flag, and each extra byte replaces the oldest byte in the pool. If the transmitter asks for data while a frame is open and nothing is committed, the block raises a one-cycle abort request and the underrun flag, and throws away any uncommitted bytes. While the underrun stays unacknowledged, the block ignores all writes and commands.

Top module: `hdlc_tx_pool`

## Requirements
- R1: After reset, wr_allow is 1 and tx_valid, tx_last, abort_req, pool_ready, overflow_flag and underrun_flag are all 0.
- R2: Committed bytes leave on tx_data in the order they were written, one byte per cycle in which tx_valid and tx_ready are both 1. While tx_valid is 1 and tx_ready is 0, tx_data holds its value.
- R3: wr_allow is 0 whenever the pool holds 32 uncommitted bytes. A write in that state sets overflow_flag one cycle later.
- R4: A write that arrives while 32 uncommitted bytes are held replaces the byte written first, which is the first byte to be sent. The pool count does not change.
- R5: overflow_flag returns to 0 in the cycle after a command is accepted.
- R6: A command is an active-high pulse of one cycle on cmd_send or cmd_end. After cmd_end, tx_last is 1 with the final byte of the block and 0 with every other byte. After cmd_send, tx_last stays 0. If both are 1 in the same cycle, the block treats it as cmd_end.
- R7: pool_ready is 1 for exactly one cycle, the cycle after the last byte of a committed block is taken. From then on wr_allow is 1 again.
- R8: While a committed block is draining, wr_allow is 0, and host writes and commands are ignored: they change neither the bytes sent nor the pool.
- R9: If a frame is open (its last block was committed with cmd_send) and tx_ready is 1 while nothing is committed, then in the next cycle abort_req is 1 for one cycle, underrun_flag is 1, and all uncommitted bytes are discarded.
- R10: While underrun_flag is 1, wr_allow and tx_valid are 0, and writes and commands are ignored. A one-cycle pulse on underrun_ack clears underrun_flag.
- R11: A command given while the pool is empty is ignored, and tx_valid stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Host byte write strobe |
| wr_data | input | 8 | Host write byte |
| cmd_send | input | 1 | Commit the pool as a block of an open frame |
| cmd_end | input | 1 | Commit the pool as the final block of a frame |
| underrun_ack | input | 1 | Acknowledge and clear the underrun flag |
| tx_ready | input | 1 | Transmitter requests or accepts a byte |
| tx_valid | output | 1 | A committed byte is offered |
| tx_data | output | 8 | Offered byte |
| tx_last | output | 1 | Offered byte ends the frame |
| abort_req | output | 1 | One-cycle request to abort the current frame |
| pool_ready | output | 1 | One-cycle event: a new block may be written |
| wr_allow | output | 1 | Host may write a byte without overflow |
| overflow_flag | output | 1 | More than 32 bytes were written before a command |
| underrun_flag | output | 1 | The transmitter ran dry in an open frame and the event is unacknowledged |

## Verification
The bench sends a short frame closed by message-end and a frame closed by both commands at once. It also sends a two-block frame, first with send-block and then with message-end, and checks that tx_last appears only on the final byte. A pool filled to exactly 32 bytes and then written twice more shows the difference between a full pool and an overflowing one, and byte order tells whether the extra writes landed in the head slot or anywhere else. Writes and commands given during a drain, during an underrun, and into an empty pool then show that each of these is ignored. For this the bench watches what leaves on tx_data afterwards.

// File: rtl/hdlc_tx_pool_pkg.sv
package hdlc_tx_pool_pkg;
  typedef enum logic {
    POOL_FILL  = 1'b0,
    POOL_DRAIN = 1'b1
  } pool_state_e;
endpackage

// File: rtl/hdlc_tx_pool_mem.sv
module hdlc_tx_pool_mem #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PTR_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] slot_q [DEPTH];
  logic [DEPTH-1:0]  slot_we;

  // one write enable per slot
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot_we
    assign slot_we[i] = we && (waddr == PTR_W'(i));
  end

  // storage carries no reset
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (slot_we[i]) slot_q[i] <= wdata;
    end
  end

  assign rdata = slot_q[raddr];
endmodule

// File: rtl/hdlc_tx_pool_ptrs.sv
module hdlc_tx_pool_ptrs #(
  parameter int DEPTH = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0] count
);
  logic [PTR_W-1:0] wr_ptr_d, rd_ptr_d;
  logic [CNT_W-1:0] count_d;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_ptr_d = wr_ptr;
    rd_ptr_d = rd_ptr;
    count_d  = count;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      count_d  = '0;
    end else if (push) begin
      wr_ptr_d = step(wr_ptr);
      count_d  = count + 1'b1;
    end else if (pop) begin
      rd_ptr_d = step(rd_ptr);
      count_d  = count - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_d;
      rd_ptr <= rd_ptr_d;
      count  <= count_d;
    end
  end

  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
endmodule

// File: rtl/hdlc_tx_pool_ctrl.sv
module hdlc_tx_pool_ctrl
  import hdlc_tx_pool_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             cmd_send,
  input  logic             cmd_end,
  input  logic             underrun_ack,
  input  logic             tx_ready,
  input  logic [CNT_W-1:0] count,
  output logic             push,
  output logic             ovw,
  output logic             pop,
  output logic             flush,
  output logic             tx_valid,
  output logic             tx_last,
  output logic             wr_allow,
  output logic             overflow_flag,
  output logic             underrun_flag,
  output logic             pool_ready,
  output logic             abort_req
);
  pool_state_e st_q, st_d;
  logic end_q, end_d;
  logic open_q, open_d;
  logic ovf_q, ovf_d;
  logic urun_q, urun_d;
  logic prdy_q, abort_q;
  logic filling, draining, full, empty, host_ok, cmd_ok, urun_hit, drain_done;

  always_comb begin
    filling    = (st_q == POOL_FILL);
    draining   = (st_q == POOL_DRAIN);
    full       = (count == CNT_W'(DEPTH));
    empty      = (count == '0);
    host_ok    = filling && !urun_q;
    push       = host_ok && wr_en && !full;
    ovw        = host_ok && wr_en && full;
    cmd_ok     = host_ok && !empty && (cmd_send || cmd_end);
    pop        = draining && !empty && tx_ready;
    drain_done = pop && (count == CNT_W'(1));
    urun_hit   = filling && open_q && tx_ready && !urun_q && !cmd_ok;
    flush      = urun_hit;
  end

  // next state
  always_comb begin
    st_d   = st_q;
    end_d  = end_q;
    open_d = open_q;
    ovf_d  = ovf_q;
    urun_d = urun_q;
    if (cmd_ok) begin
      st_d   = POOL_DRAIN;
      end_d  = cmd_end;
      open_d = !cmd_end;
    end else if (drain_done) begin
      st_d = POOL_FILL;
    end
    if (urun_hit) open_d = 1'b0;
    if (cmd_ok)   ovf_d = 1'b0;
    else if (ovw) ovf_d = 1'b1;
    if (urun_hit)          urun_d = 1'b1;
    else if (underrun_ack) urun_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= POOL_FILL;
      end_q   <= 1'b0;
      open_q  <= 1'b0;
      ovf_q   <= 1'b0;
      urun_q  <= 1'b0;
      prdy_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      end_q   <= end_d;
      open_q  <= open_d;
      ovf_q   <= ovf_d;
      urun_q  <= urun_d;
      prdy_q  <= drain_done;
      abort_q <= urun_hit;
    end
  end

  assign tx_valid      = draining && !empty;
  assign tx_last       = tx_valid && end_q && (count == CNT_W'(1));
  assign wr_allow      = host_ok && !full;
  assign overflow_flag = ovf_q;
  assign underrun_flag = urun_q;
  assign pool_ready    = prdy_q;
  assign abort_req     = abort_q;

  p_ovf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovw && !cmd_ok) |=> overflow_flag);
  p_cmd_clears_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ok |=> !overflow_flag);
  p_pool_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pool_ready |=> !pool_ready);
  p_abort_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |-> underrun_flag);
  p_abort_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |=> !abort_req);
  p_urun_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_flag |-> (!tx_valid && !wr_allow));
endmodule

// File: rtl/hdlc_tx_pool.sv
module hdlc_tx_pool #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cmd_send,
  input  logic              cmd_end,
  input  logic              underrun_ack,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_last,
  output logic              abort_req,
  output logic              pool_ready,
  output logic              wr_allow,
  output logic              overflow_flag,
  output logic              underrun_flag
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             push, ovw, pop, flush;
  logic [PTR_W-1:0] wr_ptr, rd_ptr, waddr;
  logic [CNT_W-1:0] count;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // an overflowing write lands on the head slot
  assign waddr = ovw ? rd_ptr : wr_ptr;

  hdlc_tx_pool_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .cmd_send(cmd_send),
    .cmd_end(cmd_end), .underrun_ack(underrun_ack), .tx_ready(tx_ready),
    .count(count), .push(push), .ovw(ovw), .pop(pop), .flush(flush),
    .tx_valid(tx_valid), .tx_last(tx_last), .wr_allow(wr_allow),
    .overflow_flag(overflow_flag), .underrun_flag(underrun_flag),
    .pool_ready(pool_ready), .abort_req(abort_req)
  );

  hdlc_tx_pool_ptrs #(.DEPTH(DEPTH)) i_ptrs (
    .clk(clk), .rst_n(rst_int_n), .push(push), .pop(pop), .flush(flush),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .count(count)
  );

  hdlc_tx_pool_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_mem (
    .clk(clk), .we(push || ovw), .waddr(waddr), .wdata(wr_data),
    .raddr(rd_ptr), .rdata(tx_data)
  );

  p_stall_stable_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
endmodule

// File: tb/test_hdlc_tx_pool.sv
module test_hdlc_tx_pool;
  localparam int CLK_PERIOD = 10;
  localparam int POOL = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, cmd_send = 1'b0, cmd_end = 1'b0;
  logic underrun_ack = 1'b0, tx_ready = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic tx_valid, tx_last, abort_req, pool_ready, wr_allow;
  logic overflow_flag, underrun_flag;
  logic [7:0] tx_data;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [7:0] pool_m[$];
  logic [7:0] exp_data[$];
  bit         exp_last[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  hdlc_tx_pool i_hdlc_tx_pool (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cmd_send(cmd_send), .cmd_end(cmd_end), .underrun_ack(underrun_ack),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_last(tx_last), .abort_req(abort_req), .pool_ready(pool_ready),
    .wr_allow(wr_allow), .overflow_flag(overflow_flag),
    .underrun_flag(underrun_flag)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      if (exp_data.size() == 0) begin
        check(1'b0, "R2 unexpected byte", tx_data, 0);
      end else begin
        logic [7:0] d;
        bit l;
        d = exp_data.pop_front();
        l = exp_last.pop_front();
        check(tx_data == d, "R2 byte order", tx_data, d);
        check(tx_last == l, "R6 last marker", tx_last, l);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++;
      checks++;
      $display("FAIL R2 watchdog: actual %0d expected below %0d", cycles, 20000);
      summary();
      $finish;
    end
  end

  // all tasks start and end one time unit after a rising edge
  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic host_write(input logic [7:0] b, input bit stored);
    wr_en = 1'b1; wr_data = b;
    @(posedge clk); #1;
    wr_en = 1'b0;
    if (stored) begin
      if (pool_m.size() < POOL) pool_m.push_back(b);
      else pool_m[0] = b;
    end
  endtask

  task automatic issue(input bit snd, input bit fin, input bit taken);
    cmd_send = snd; cmd_end = fin;
    @(posedge clk); #1;
    cmd_send = 1'b0; cmd_end = 1'b0;
    if (taken) begin
      for (int k = 0; k < pool_m.size(); k++) begin
        exp_data.push_back(pool_m[k]);
        exp_last.push_back(fin && (k == pool_m.size() - 1));
      end
      pool_m.delete();
    end
  endtask

  task automatic pull(input int n);
    tx_ready = 1'b1;
    repeat (n) @(posedge clk);
    #1;
    tx_ready = 1'b0;
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    check(wr_allow == 1'b1, "R1 wr_allow", wr_allow, 1);
    check(tx_valid == 1'b0 && tx_last == 1'b0, "R1 tx idle", tx_valid, 0);
    check(abort_req == 1'b0 && pool_ready == 1'b0, "R1 events", abort_req, 0);
    check(overflow_flag == 1'b0 && underrun_flag == 1'b0, "R1 flags", overflow_flag, 0);

    // short frame closed by message end (R2, R6, R7)
    for (int i = 0; i < 5; i++) host_write(8'h10 + 8'(i), 1'b1);
    issue(1'b0, 1'b1, 1'b1);
    check(wr_allow == 1'b0, "R8 closed while draining", wr_allow, 0);
    idle(2);
    check(tx_valid == 1'b1 && tx_data == 8'h10, "R2 held during stall", tx_data, 8'h10);
    pull(5);
    check(pool_ready == 1'b1, "R7 pool ready pulse", pool_ready, 1);
    idle(1);
    check(pool_ready == 1'b0 && wr_allow == 1'b1, "R7 pulse ends, pool open", pool_ready, 0);

    // both commands at once act as message end (R6)
    for (int i = 0; i < 3; i++) host_write(8'hA0 + 8'(i), 1'b1);
    issue(1'b1, 1'b1, 1'b1);
    pull(3);

    // full pool, then overflow (R3, R4, R5)
    for (int i = 0; i < POOL; i++) host_write(8'h40 + 8'(i), 1'b1);
    check(wr_allow == 1'b0, "R3 wr_allow low at 32", wr_allow, 0);
    check(overflow_flag == 1'b0, "R3 no overflow at exactly 32", overflow_flag, 0);
    host_write(8'hF0, 1'b1);
    host_write(8'hF1, 1'b1);
    check(overflow_flag == 1'b1, "R3 overflow flag", overflow_flag, 1);
    issue(1'b0, 1'b1, 1'b1);
    check(overflow_flag == 1'b0, "R5 overflow cleared by command", overflow_flag, 0);
    // writes and commands during drain are ignored (R8)
    host_write(8'h99, 1'b0);
    issue(1'b0, 1'b1, 1'b0);
    check(wr_allow == 1'b0 && tx_valid == 1'b1, "R8 drain continues", tx_valid, 1);
    pull(POOL);
    check(pool_ready == 1'b1, "R7 pool ready after 32", pool_ready, 1);
    // empty pool command ignored (R11, and R8 byte was not stored)
    issue(1'b0, 1'b1, 1'b0);
    idle(2);
    check(tx_valid == 1'b0, "R11 empty command ignored", tx_valid, 0);

    // two-block frame (R6, R7)
    for (int i = 0; i < 4; i++) host_write(8'h60 + 8'(i), 1'b1);
    issue(1'b1, 1'b0, 1'b1);
    pull(4);
    check(pool_ready == 1'b1 && underrun_flag == 1'b0, "R7 mid-frame pool ready", pool_ready, 1);
    for (int i = 0; i < 3; i++) host_write(8'h70 + 8'(i), 1'b1);
    issue(1'b0, 1'b1, 1'b1);
    pull(3);

    // underrun (R9, R10)
    host_write(8'h80, 1'b1);
    host_write(8'h81, 1'b1);
    issue(1'b1, 1'b0, 1'b1);
    pull(2);
    host_write(8'hEE, 1'b1);
    tx_ready = 1'b1;
    @(posedge clk); #1;
    tx_ready = 1'b0;
    pool_m.delete();
    check(abort_req == 1'b1, "R9 abort pulse", abort_req, 1);
    check(underrun_flag == 1'b1, "R9 underrun flag", underrun_flag, 1);
    check(wr_allow == 1'b0 && tx_valid == 1'b0, "R10 blocked", wr_allow, 0);
    idle(1);
    check(abort_req == 1'b0, "R9 abort one cycle", abort_req, 0);
    host_write(8'h55, 1'b0);
    issue(1'b0, 1'b1, 1'b0);
    idle(1);
    check(tx_valid == 1'b0 && underrun_flag == 1'b1, "R10 command ignored", tx_valid, 0);
    underrun_ack = 1'b1;
    @(posedge clk); #1;
    underrun_ack = 1'b0;
    check(underrun_flag == 1'b0 && wr_allow == 1'b1, "R10 acknowledge clears", underrun_flag, 0);
    issue(1'b0, 1'b1, 1'b0);
    idle(1);
    check(tx_valid == 1'b0, "R9 uncommitted bytes discarded", tx_valid, 0);
    host_write(8'hC0, 1'b1);
    host_write(8'hC1, 1'b1);
    issue(1'b0, 1'b1, 1'b1);
    pull(2);
    idle(2);

    check(exp_data.size() == 0, "R2 all expected bytes sent", exp_data.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule